// File: doc/BRIEF.md
# Serial Configuration Receiver with Chain Forwarding

This block takes a bit-serial configuration stream, one bit per rising edge of the configuration clock. A program request starts it over. It first wipes its configuration store in two complete zeroing passes, holding the shared open-drain status line low the whole time. After that it waits until nothing on the board holds that line low. It then takes its own quota of bits and packs them into words that it writes to the store. It checks a CRC carried at the tail of its quota. On a match it counts out a fixed start-up interval and raises `done`. On a mismatch it pulls the status line low again and stays there.

Once its own quota has been taken, every further bit offered on the input passes to `dout` one clock later, so the next device in a daisy chain receives it. The input stream is valid/ready. A bit counts as transferred only on a rising edge where `din_valid` and `din_ready` are both high. The block lowers `din_ready` to hold back the source while it is clearing or waiting. The chain output carries `dout_valid` but has no ready input, because a serial chain has no way to stall the upstream device. Downstream devices must take every bit that is marked valid.

Top module: `cfg_serial_rx`

## Requirements
- R1: A bit is taken on a rising clock edge where `din_valid` and `din_ready` are both high. Every WORD_W bits taken during loading form one word, with the first bit of the word in its most significant position. That word is written with `wr_en` on the clock after its last bit, at `wr_addr` equal to the word index counted from 0.
- R2: After a program request, the block writes zero to every address from 0 to CFG_BITS/WORD_W-1, one address per clock. It then repeats the same pass a second time. `init_drive_low` is high during both passes and goes low once they end.
- R3: After clearing, `din_ready` rises only on the clock after `init_in` is sampled high. `init_in` is the wired status line, which is low while this block or any other device holds it.
- R4: The CRC is CRC-16 with polynomial 0x8005, initial value 0, computed most significant bit first. It covers the first CFG_BITS-16 bits taken. The last 16 bits of the quota hold the expected value, first bit as the MSB. On a mismatch `init_drive_low` goes high one clock after the check cycle, and `done` never rises.
- R5: On a match, the check cycle is followed by exactly START_CYC clocks of start-up. Then `done` goes high and stays high until the next program request.
- R6: From the check cycle onward, including start-up, done and failure, every bit taken appears on `dout` with `dout_valid` high one clock later.
- R7: Whenever no bit was forwarded at the previous edge, `dout` is 1 and `dout_valid` is 0. This covers the whole time before the block's own quota is complete.
- R8: A program request at any moment aborts the current activity. Clearing then restarts from address 0.
- R9: `din_ready` is low during both clearing passes and while waiting for the status line. Bits offered at those times are not taken, and `din_valid` has no effect then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| prog_req | input | 1 | Program request, synchronous, active high |
| init_in | input | 1 | Sensed level of the wired status line |
| din | input | 1 | Serial stream bit |
| din_valid | input | 1 | Stream bit present |
| din_ready | output | 1 | Block takes a bit at this edge |
| init_drive_low | output | 1 | Pull the status line low |
| done | output | 1 | Configuration complete |
| dout | output | 1 | Forwarded chain bit, idle 1 |
| dout_valid | output | 1 | Forwarded bit present |
| wr_en | output | 1 | Store write strobe |
| wr_addr | output | ADDR_W | Store word address |
| wr_data | output | WORD_W | Store word data |

## Verification
Two events can share a cycle. The first is the last own-quota bit, which closes the final word write and completes loading. The second is the first forwarded bit, which the check cycle already accepts. The bench keeps `din_valid` high straight across that boundary, so the final word write on `wr_en` and the first forwarded bit on `dout` land on consecutive edges. A second run inserts gaps in `din_valid` so the boundary falls at other phases. A behavioural model advances on the same edges and predicts `wr_*`, `dout` and `dout_valid`, and every clock is judged against that model. That includes the start-up countdown while stream bits are still passing through.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR1,
    ST_CLEAR2,
    ST_WAIT,
    ST_LOAD,
    ST_CHECK,
    ST_START,
    ST_DONE,
    ST_FAIL
  } cfg_state_e;

  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam int CRC_W = 16;
endpackage

// File: rtl/cfg_crc16.sv
module cfg_crc16 #(
  parameter logic [15:0] POLY = 16'h8005
) (
  input  logic        clk,
  input  logic        clr,
  input  logic        en,
  input  logic        bit_in,
  output logic [15:0] crc
);
  logic fb;
  assign fb = crc[15] ^ bit_in;

  always_ff @(posedge clk) begin
    if (clr) begin
      crc <= '0;
    end else if (en) begin
      crc <= {crc[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
    end
  end
endmodule

// File: rtl/cfg_fwd.sv
module cfg_fwd (
  input  logic clk,
  input  logic prog_req,
  input  logic active,
  input  logic din,
  input  logic din_valid,
  output logic dout,
  output logic dout_valid
);
  always_ff @(posedge clk) begin
    if (prog_req) begin
      dout       <= 1'b1;
      dout_valid <= 1'b0;
    end else if (active && din_valid) begin
      dout       <= din;
      dout_valid <= 1'b1;
    end else begin
      dout       <= 1'b1;
      dout_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_rx_pkg::*;
#(
  parameter int CFG_BITS  = 64,
  parameter int WORD_W    = 8,
  parameter int START_CYC = 8,
  parameter int ADDR_W    = 3
) (
  input  logic               clk,
  input  logic               prog_req,
  input  logic               init_in,
  input  logic               din,
  input  logic               din_valid,
  input  logic [15:0]        crc_calc,
  output cfg_state_e         state,
  output logic               crc_clr,
  output logic               crc_en,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [WORD_W-1:0]  wr_data
);
  localparam int NWORDS    = CFG_BITS / WORD_W;
  localparam int DATA_BITS = CFG_BITS - CRC_W;
  localparam int BW        = $clog2(CFG_BITS);
  localparam int WBW       = $clog2(WORD_W);

  logic [BW-1:0]     bitcnt;
  logic [BW-1:0]     cnt;
  logic [WBW-1:0]    wbit;
  logic [ADDR_W-1:0] widx;
  logic [WORD_W-2:0] shreg;
  logic [WORD_W-1:0] word_next;
  logic [15:0]       rx_crc;
  logic              in_data;

  assign word_next = {shreg, din};
  assign in_data   = (bitcnt < BW'(DATA_BITS));
  assign crc_clr   = prog_req || (state == ST_WAIT);
  assign crc_en    = (state == ST_LOAD) && din_valid && in_data;

  always_ff @(posedge clk) begin
    if (prog_req) begin
      state   <= ST_CLEAR1;
      cnt     <= '0;
      bitcnt  <= '0;
      wbit    <= '0;
      widx    <= '0;
      shreg   <= '0;
      rx_crc  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      case (state)
        ST_CLEAR1, ST_CLEAR2: begin
          wr_en   <= 1'b1;
          wr_addr <= cnt[ADDR_W-1:0];
          wr_data <= '0;
          if (cnt == BW'(NWORDS - 1)) begin
            cnt   <= '0;
            state <= (state == ST_CLEAR1) ? ST_CLEAR2 : ST_WAIT;
          end else begin
            cnt <= cnt + BW'(1);
          end
        end
        ST_WAIT: begin
          if (init_in) begin
            state  <= ST_LOAD;
            bitcnt <= '0;
            wbit   <= '0;
            widx   <= '0;
          end
        end
        ST_LOAD: begin
          if (din_valid) begin
            shreg <= word_next[WORD_W-2:0];
            if (!in_data) rx_crc <= {rx_crc[14:0], din};
            if (wbit == WBW'(WORD_W - 1)) begin
              wr_en   <= 1'b1;
              wr_addr <= widx;
              wr_data <= word_next;
              widx    <= widx + ADDR_W'(1);
              wbit    <= '0;
            end else begin
              wbit <= wbit + WBW'(1);
            end
            if (bitcnt == BW'(CFG_BITS - 1)) state <= ST_CHECK;
            else bitcnt <= bitcnt + BW'(1);
          end
        end
        ST_CHECK: begin
          cnt   <= '0;
          state <= (crc_calc == rx_crc) ? ST_START : ST_FAIL;
        end
        ST_START: begin
          if (cnt == BW'(START_CYC - 1)) state <= ST_DONE;
          else cnt <= cnt + BW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_rx_pkg::*;
#(
  parameter int CFG_BITS  = 64,
  parameter int WORD_W    = 8,
  parameter int START_CYC = 8,
  localparam int ADDR_W   = $clog2(CFG_BITS / WORD_W)
) (
  input  logic              clk,
  input  logic              prog_req,
  input  logic              init_in,
  input  logic              din,
  input  logic              din_valid,
  output logic              din_ready,
  output logic              init_drive_low,
  output logic              done,
  output logic              dout,
  output logic              dout_valid,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  cfg_state_e  state;
  logic        crc_clr;
  logic        crc_en;
  logic [15:0] crc_calc;
  logic        fwd_on;

  assign fwd_on = (state == ST_CHECK) || (state == ST_START) ||
                  (state == ST_DONE)  || (state == ST_FAIL);
  assign din_ready      = fwd_on || (state == ST_LOAD);
  assign init_drive_low = (state == ST_CLEAR1) || (state == ST_CLEAR2) ||
                          (state == ST_FAIL);
  assign done           = (state == ST_DONE);

  cfg_seq #(
    .CFG_BITS (CFG_BITS),
    .WORD_W   (WORD_W),
    .START_CYC(START_CYC),
    .ADDR_W   (ADDR_W)
  ) i_seq (
    .clk      (clk),
    .prog_req (prog_req),
    .init_in  (init_in),
    .din      (din),
    .din_valid(din_valid),
    .crc_calc (crc_calc),
    .state    (state),
    .crc_clr  (crc_clr),
    .crc_en   (crc_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  cfg_crc16 #(.POLY(CRC_POLY)) i_crc (
    .clk   (clk),
    .clr   (crc_clr),
    .en    (crc_en),
    .bit_in(din),
    .crc   (crc_calc)
  );

  cfg_fwd i_fwd (
    .clk       (clk),
    .prog_req  (prog_req),
    .active    (fwd_on),
    .din       (din),
    .din_valid (din_valid),
    .dout      (dout),
    .dout_valid(dout_valid)
  );
endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              prog_req,
  input logic              init_in,
  input logic              din,
  input logic              din_valid,
  input logic              din_ready,
  input logic              init_drive_low,
  input logic              done,
  input logic              dout,
  input logic              dout_valid,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data
);
  AST_CLEAR_WRITES_ZERO: assert property (@(posedge clk) disable iff (prog_req)
    (wr_en && init_drive_low) |-> (wr_data == '0)); // R2

  AST_LOAD_AFTER_INIT: assert property (@(posedge clk) disable iff (prog_req)
    ($rose(din_ready) && !done) |-> $past(init_in)); // R3

  AST_NO_DONE_ON_FAIL: assert property (@(posedge clk) disable iff (prog_req)
    done |-> !init_drive_low); // R4

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (prog_req)
    done |=> done); // R5

  AST_FWD_COPY: assert property (@(posedge clk) disable iff (prog_req)
    (din_valid && din_ready && done) |=> (dout_valid && (dout == $past(din)))); // R6

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (prog_req)
    !dout_valid |-> dout); // R7

  AST_NO_FWD_UNREADY: assert property (@(posedge clk) disable iff (prog_req)
    !din_ready |=> !dout_valid); // R7
endmodule

bind cfg_serial_rx cfg_serial_rx_chk #(.WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_cfg_serial_rx.sv
module test_cfg_serial_rx;
  localparam int LEN  = 64;
  localparam int W    = 8;
  localparam int NW   = LEN / W;
  localparam int DATA = LEN - 16;
  localparam int AW   = $clog2(NW);

  logic clk = 1'b0;
  logic prog_req = 1'b1;
  logic din = 1'b0;
  logic din_valid = 1'b0;
  logic ext_hold = 1'b0;
  logic init_in;
  logic din_ready, init_drive_low, done, dout, dout_valid, wr_en;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  wr_data;

  int vectors = 0;
  int errors = 0;
  int cyc = 0;
  bit gap = 1'b0;
  bit finished = 1'b0;
  bit stream[$];

  always #10 clk = ~clk;

  assign init_in = !init_drive_low && !ext_hold;

  cfg_serial_rx #(.CFG_BITS(LEN), .WORD_W(W), .START_CYC(8)) i_cfg_serial_rx (
    .clk(clk), .prog_req(prog_req), .init_in(init_in), .din(din),
    .din_valid(din_valid), .din_ready(din_ready),
    .init_drive_low(init_drive_low), .done(done), .dout(dout),
    .dout_valid(dout_valid), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  // Behavioural reference: 0 clear1, 1 clear2, 2 wait, 3 load, 4 check,
  // 5 start-up, 6 done, 7 fail
  int ms = 0, mcnt = 0, mbits = 0, mword = 0;
  logic [15:0] mcrc = 0, mrx = 0;
  int m_wr_en = 0, m_wr_addr = 0, m_wr_data = 0, m_dout = 1, m_dv = 0;
  bit m_fwd, m_ilow, m_iin;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
  endfunction

  always @(posedge clk) begin
    m_fwd  = (ms >= 4);
    m_ilow = (ms <= 1) || (ms == 7);
    m_iin  = !m_ilow && !ext_hold;
    if (prog_req) begin
      ms = 0; mcnt = 0; m_wr_en = 0; m_wr_addr = 0; m_wr_data = 0;
      m_dout = 1; m_dv = 0;
    end else begin
      m_wr_en = 0;
      m_dv    = (m_fwd && din_valid) ? 1 : 0;
      m_dout  = (m_fwd && din_valid) ? int'(din) : 1;
      case (ms)
        0, 1: begin
          m_wr_en = 1; m_wr_addr = mcnt; m_wr_data = 0;
          if (mcnt == NW - 1) begin mcnt = 0; ms = ms + 1; end
          else mcnt = mcnt + 1;
        end
        2: if (m_iin) begin ms = 3; mbits = 0; mcrc = 0; mrx = 0; mword = 0; end
        3: if (din_valid) begin
          if (mbits < DATA) mcrc = crc_step(mcrc, din);
          else mrx = {mrx[14:0], din};
          mword = ((mword << 1) | int'(din)) & ((1 << W) - 1);
          if (mbits % W == W - 1) begin
            m_wr_en = 1; m_wr_addr = mbits / W; m_wr_data = mword;
          end
          mbits = mbits + 1;
          if (mbits == LEN) ms = 4;
        end
        4: begin mcnt = 0; ms = (mcrc == mrx) ? 5 : 7; end
        5: if (mcnt == 7) ms = 6; else mcnt = mcnt + 1;
        default: ;
      endcase
    end
  end

  task automatic chk(string tag, string name, int got, int exp);
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, name, got, exp, cyc);
    end
  endtask

  task automatic compare();
    vectors++;
    chk("R1/R2", "wr_en", int'(wr_en), m_wr_en);
    if (m_wr_en != 0) begin
      chk("R1/R2", "wr_addr", int'(wr_addr), m_wr_addr);
      chk("R1/R2", "wr_data", int'(wr_data), m_wr_data);
    end
    chk("R2/R4", "init_drive_low", int'(init_drive_low), ((ms <= 1) || (ms == 7)) ? 1 : 0);
    chk("R5", "done", int'(done), (ms == 6) ? 1 : 0);
    chk("R3/R9", "din_ready", int'(din_ready), (ms >= 3) ? 1 : 0);
    chk("R6/R7", "dout_valid", int'(dout_valid), m_dv);
    chk("R6/R7", "dout", int'(dout), m_dout);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cyc++;
      compare();
      if (stream.size() > 0 && !(gap && (cyc % 3 == 2))) begin
        din_valid = 1'b1;
        din = stream[0];
        if (din_ready && !prog_req) void'(stream.pop_front());
      end else begin
        din_valid = 1'b0;
        din = 1'b0;
      end
    end
  endtask

  task automatic push_frame(logic [47:0] payload, bit corrupt, int extra);
    logic [15:0] c;
    c = 16'h0000;
    for (int i = 47; i >= 0; i--) begin
      stream.push_back(payload[i]);
      c = crc_step(c, payload[i]);
    end
    if (corrupt) c = c ^ 16'h0100;
    for (int i = 15; i >= 0; i--) stream.push_back(c[i]);
    for (int i = 0; i < extra; i++) stream.push_back(i[0] ^ i[2]);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    prog_req = 1'b1;
    run(3);
    // reset state
    chk("R2", "init_drive_low after program", int'(init_drive_low), 1);
    chk("R7", "dout idle", int'(dout), 1);
    // Test A: external hold on status line, gapped stream, forwarding
    ext_hold = 1'b1; gap = 1'b1;
    push_frame(48'hA5C3_0F1E_7B29, 1'b0, 20);
    prog_req = 1'b0;
    run(18);
    chk("R3", "released after clear", int'(init_drive_low), 0);
    chk("R9", "not ready while line held", int'(din_ready), 0);
    chk("R9", "bits left untaken", stream.size(), LEN + 20);
    run(5);
    ext_hold = 1'b0;
    run(200);
    chk("R5", "done after good frame", int'(done), 1);
    chk("R6", "extra bits all forwarded", stream.size(), 0);
    // Test B: bad CRC, continuous stream
    prog_req = 1'b1; gap = 1'b0;
    run(2);
    push_frame(48'h1234_5678_9ABC, 1'b1, 10);
    prog_req = 1'b0;
    run(120);
    chk("R4", "init low on crc error", int'(init_drive_low), 1);
    chk("R4", "no done on crc error", int'(done), 0);
    // Test C: abort in the middle of loading
    prog_req = 1'b1;
    run(2);
    push_frame(48'hFFFF_0000_AAAA, 1'b0, 4);
    prog_req = 1'b0;
    run(47);
    prog_req = 1'b1;
    stream.delete();
    run(1);
    prog_req = 1'b0;
    chk("R8", "restart clears", int'(init_drive_low), 1);
    chk("R8", "load aborted", int'(din_ready), 0);
    push_frame(48'h0001_8000_C3C3, 1'b0, 6);
    run(120);
    chk("R5", "done after restart", int'(done), 1);
    // Test D: abort during start-up
    prog_req = 1'b1;
    run(2);
    push_frame(48'h5A5A_5A5A_0F0F, 1'b0, 8);
    prog_req = 1'b0;
    run(85);
    prog_req = 1'b1;
    stream.delete();
    run(1);
    prog_req = 1'b0;
    chk("R8", "no done after abort", int'(done), 0);
    run(30);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule